// File: doc/BRIEF.md
# Lockable Set-Associative Cache Tag Controller

This block keeps the tag, valid and lock state of an 8-way set-associative cache with 512 sets and 32-byte lines. It also decides, for every CPU access, whether the line is present or which way should receive it. Software can pin individual lines so they are never evicted. That keeps a critical working set resident and makes the access time of a task independent of its neighbours. Lock, unlock and invalidate commands name a line by its address.

On a miss, a single rotating pointer shared by all sets proposes a victim. Ways that are locked, or masked off by the per-access way-disable input, are skipped, and the pointer walks upward and wraps until an eligible way is found. If no way qualifies, the access is passed to memory without allocation and flagged as bypass. Memory traffic goes through a simple request/acknowledge refill port. The data array itself lives outside this block.

Top module: `cache_lock_ctrl`

## Requirements
- R1: An address splits into byte offset [4:0], set index [13:5] and tag [31:14]. During a refill, `refill_addr` carries the request address with bits [4:0] forced to zero.
- R2: After reset every line is invalid and unlocked and the victim pointer is 0. The first read to any set misses and allocates way 0.
- R3: Op codes are read=0 and write=1. When a valid line with a matching tag exists, the response has `resp_hit`=1 and `resp_way` set to that way, and no refill is issued.
- R4: On a read, write or lock miss, the victim is the first way at or above the pointer (wrapping from 7 to 0) that is neither locked nor disabled by `way_disable` as sampled with the request. That way is refilled and reported in `resp_way`, and the pointer then becomes that way plus one, modulo 8.
- R5: When every way of the set is locked or disabled, a miss returns `resp_bypass`=1, `resp_hit`=0 and `resp_way`=0. A refill is still issued for the memory access, but nothing is allocated and the pointer does not move.
- R6: A locked line is never chosen as a victim, so it keeps hitting in its way however many misses hit its set.
- R7: Invalidate is op code 4. It clears the valid bit of a hit line even if that line is locked, and the lock bit stays. The next miss to that line refills the same way, ahead of pointer selection and without moving the pointer. The response reports whether the line was valid.
- R8: Lock is op code 2. On a hit it sets the lock bit of the hit way. On a miss it allocates as in R4 (or R7), then sets the lock bit of the refilled way.
- R9: Unlock is op code 3. It clears the lock bit of the matching line, which then becomes eligible for replacement again.
- R10: `refill_req` stays high with a stable `refill_addr` until `refill_ack` is seen. `resp_valid` is a one-cycle pulse. `req_ready` is high only when the block is idle.
- R11: The pointer is shared by all sets and moves only on allocating misses chosen by the pointer. Hits leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Block idle, able to take a request |
| req_op | input | 3 | Operation code (read, write, lock, unlock, invalidate) |
| req_addr | input | 32 | Byte address of the access |
| way_disable | input | 8 | Ways excluded from allocation for this request |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | A valid matching line was present |
| resp_bypass | output | 1 | Access served from memory without allocation |
| resp_way | output | 3 | Hit or allocated way |
| refill_req | output | 1 | Memory line fetch request |
| refill_addr | output | 32 | Line-aligned fetch address |
| refill_ack | input | 1 | Memory has returned the line |

## Verification
The hardest state to reach is a set whose ways are all locked or disabled, combined with a locked line that has been invalidated. Only these conditions make bypass and same-way reclaim visible. Random addresses spread across 512 sets almost never produce them. The stimulus therefore confines random traffic to three sets and a dozen tags, and uses lock commands and occasional disable masks so that sets saturate. Directed sequences fill one set completely with locks, invalidate a locked line, unlock a single way and force a wrap of the pointer past disabled ways.

// File: rtl/cache_lock_pkg.sv
`timescale 1ns/1ps
package cache_lock_pkg;

   typedef enum logic [2:0] {
      OP_READ   = 3'd0,
      OP_WRITE  = 3'd1,
      OP_LOCK   = 3'd2,
      OP_UNLOCK = 3'd3,
      OP_INVAL  = 3'd4
   } cl_op_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LOOKUP = 2'd1,
      ST_REFILL = 2'd2,
      ST_DONE   = 2'd3
   } cl_state_e;

endpackage

// File: rtl/clc_way_store.sv
`timescale 1ns/1ps
// Tag, valid and lock state of one way across all sets.
module clc_way_store #(
   parameter int SETS  = 512,
   parameter int TAG_W = 18,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] set_idx,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_valid,
   output logic             rd_lock,
   input  logic             fill_we,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             lock_set,
   input  logic             lock_clr,
   input  logic             val_clr
);

   logic [TAG_W-1:0] tag_mem [SETS];
   logic [SETS-1:0]  valid_q;
   logic [SETS-1:0]  lock_q;

   always_ff @(posedge clk) begin
      if (fill_we) tag_mem[set_idx] <= fill_tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         lock_q  <= '0;
      end else begin
         if (fill_we)      valid_q[set_idx] <= 1'b1;
         else if (val_clr) valid_q[set_idx] <= 1'b0;
         if (lock_set)      lock_q[set_idx] <= 1'b1;
         else if (lock_clr) lock_q[set_idx] <= 1'b0;
      end
   end

   assign rd_tag   = tag_mem[set_idx];
   assign rd_valid = valid_q[set_idx];
   assign rd_lock  = lock_q[set_idx];

endmodule

// File: rtl/clc_victim_pick.sv
`timescale 1ns/1ps
// Rotating search: first eligible way at or above start, wrapping.
module clc_victim_pick #(
   parameter int WAYS = 8,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  elig,
   input  logic [WAY_W-1:0] start,
   output logic             found,
   output logic [WAY_W-1:0] way
);

   always_comb begin
      found = 1'b0;
      way   = start;
      for (int i = 0; i < WAYS; i++) begin
         if (!found && elig[start + WAY_W'(i)]) begin
            found = 1'b1;
            way   = start + WAY_W'(i);
         end
      end
   end

endmodule

// File: rtl/cache_lock_ctrl.sv
`timescale 1ns/1ps
module cache_lock_ctrl
   import cache_lock_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int SETS       = 512,
   parameter int WAYS       = 8,
   localparam int OFF_W = $clog2(LINE_BYTES),
   localparam int IDX_W = $clog2(SETS),
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
   localparam int WAY_W = $clog2(WAYS),
   localparam int LINE_W = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WAYS-1:0]   way_disable,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic              resp_bypass,
   output logic [WAY_W-1:0]  resp_way,
   output logic              refill_req,
   output logic [ADDR_W-1:0] refill_addr,
   input  logic              refill_ack
);

   initial begin
      assert (WAYS >= 2 && (WAYS & (WAYS - 1)) == 0)
         else $fatal(1, "WAYS must be a power of two, at least 2");
      assert (SETS >= 2 && (SETS & (SETS - 1)) == 0)
         else $fatal(1, "SETS must be a power of two, at least 2");
      assert (LINE_BYTES >= 2 && (LINE_BYTES & (LINE_BYTES - 1)) == 0)
         else $fatal(1, "LINE_BYTES must be a power of two");
      assert (TAG_W >= 1) else $fatal(1, "address too narrow for tag");
   end

   cl_state_e        st_q;
   cl_op_e           op_q;
   logic [LINE_W-1:0] line_q;
   logic [WAYS-1:0]  dis_q;
   logic [WAY_W-1:0] tgt_q, way_q, ctr_q;
   logic             hit_q, byp_q, use_ctr_q;

   logic             unused_off;
   assign unused_off = ^req_addr[OFF_W-1:0];

   wire [IDX_W-1:0] set_q = line_q[IDX_W-1:0];
   wire [TAG_W-1:0] tag_q = line_q[LINE_W-1:IDX_W];

   logic [TAG_W-1:0] rd_tag [WAYS];
   logic [WAYS-1:0]  rd_valid, rd_lock;
   logic [WAYS-1:0]  fill_we, lock_set, lock_clr, val_clr;
   logic [WAYS-1:0]  tag_eq, hit_vec, match_vec, recl_vec, elig_vec;
   logic [WAY_W-1:0] hit_way, recl_way, pick_way;
   logic             any_hit, any_recl, pick_found, alloc_op;
   logic             alloc_fire;
   logic [WAY_W-1:0] alloc_way;
   logic [WAYS-1:0]  lock_vec;

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      clc_way_store #(.SETS(SETS), .TAG_W(TAG_W)) store_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_idx  (set_q),
         .rd_tag   (rd_tag[g]),
         .rd_valid (rd_valid[g]),
         .rd_lock  (rd_lock[g]),
         .fill_we  (fill_we[g]),
         .fill_tag (tag_q),
         .lock_set (lock_set[g]),
         .lock_clr (lock_clr[g]),
         .val_clr  (val_clr[g])
      );
      assign tag_eq[g]    = (rd_tag[g] == tag_q);
      assign hit_vec[g]   = tag_eq[g] & rd_valid[g];
      assign match_vec[g] = tag_eq[g] & (rd_valid[g] | rd_lock[g]);
      assign recl_vec[g]  = tag_eq[g] & rd_lock[g] & ~rd_valid[g];
      assign elig_vec[g]  = ~rd_lock[g] & ~dis_q[g];
   end

   assign lock_vec = rd_lock;

   always_comb begin
      hit_way  = '0;
      recl_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (hit_vec[w])  hit_way  = WAY_W'(w);
         if (recl_vec[w]) recl_way = WAY_W'(w);
      end
   end

   assign any_hit  = |hit_vec;
   assign any_recl = |recl_vec;
   assign alloc_op = (op_q == OP_READ) || (op_q == OP_WRITE) || (op_q == OP_LOCK);

   clc_victim_pick #(.WAYS(WAYS)) pick_i (
      .elig  (elig_vec),
      .start (ctr_q),
      .found (pick_found),
      .way   (pick_way)
   );

   assign alloc_fire = (st_q == ST_LOOKUP) && alloc_op && !any_hit && !any_recl && pick_found;
   assign alloc_way  = pick_way;

   always_comb begin
      fill_we  = '0;
      lock_set = '0;
      lock_clr = '0;
      val_clr  = '0;
      if (st_q == ST_LOOKUP) begin
         if (op_q == OP_LOCK && any_hit) lock_set[hit_way] = 1'b1;
         if (op_q == OP_UNLOCK)          lock_clr = match_vec;
         if (op_q == OP_INVAL)           val_clr  = hit_vec;
      end else if (st_q == ST_REFILL && refill_ack && !byp_q) begin
         fill_we[tgt_q] = 1'b1;
         if (op_q == OP_LOCK) lock_set[tgt_q] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         op_q      <= OP_READ;
         line_q    <= '0;
         dis_q     <= '0;
         tgt_q     <= '0;
         way_q     <= '0;
         ctr_q     <= '0;
         hit_q     <= 1'b0;
         byp_q     <= 1'b0;
         use_ctr_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (req_valid) begin
               op_q   <= cl_op_e'(req_op);
               line_q <= req_addr[ADDR_W-1:OFF_W];
               dis_q  <= way_disable;
               st_q   <= ST_LOOKUP;
            end
            ST_LOOKUP: begin
               hit_q     <= any_hit;
               byp_q     <= 1'b0;
               use_ctr_q <= 1'b0;
               if (alloc_op && !any_hit) begin
                  st_q <= ST_REFILL;
                  if (any_recl) begin
                     tgt_q <= recl_way;
                     way_q <= recl_way;
                  end else if (pick_found) begin
                     tgt_q     <= pick_way;
                     way_q     <= pick_way;
                     use_ctr_q <= 1'b1;
                  end else begin
                     byp_q <= 1'b1;
                     way_q <= '0;
                  end
               end else begin
                  way_q <= any_hit ? hit_way : '0;
                  st_q  <= ST_DONE;
               end
            end
            ST_REFILL: if (refill_ack) begin
               if (use_ctr_q) ctr_q <= tgt_q + 1'b1;
               st_q <= ST_DONE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready   = (st_q == ST_IDLE);
   assign resp_valid  = (st_q == ST_DONE);
   assign resp_hit    = hit_q;
   assign resp_bypass = byp_q;
   assign resp_way    = way_q;
   assign refill_req  = (st_q == ST_REFILL);
   assign refill_addr = {line_q, {OFF_W{1'b0}}};

endmodule

// File: rtl/clc_checker.sv
`timescale 1ns/1ps
module clc_checker #(
   parameter int WAYS   = 8,
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 5,
   localparam int WAY_W = $clog2(WAYS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              resp_valid,
   input logic              resp_hit,
   input logic              resp_bypass,
   input logic              refill_req,
   input logic              refill_ack,
   input logic [ADDR_W-1:0] refill_addr,
   input logic              alloc_fire,
   input logic [WAY_W-1:0]  alloc_way,
   input logic [WAYS-1:0]   lock_vec,
   input logic [WAYS-1:0]   dis_q
);

   assert_line_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      refill_req |-> refill_addr[OFF_W-1:0] == '0);

   assert_victim_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_fire |-> !dis_q[alloc_way]);

   assert_bypass_no_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_bypass) |-> !resp_hit);

   assert_victim_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_fire |-> !lock_vec[alloc_way]);

   assert_refill_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (refill_req && !refill_ack) |=> (refill_req && $stable(refill_addr)));

   assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid || refill_req) |-> !req_ready);

endmodule

bind cache_lock_ctrl clc_checker #(
   .WAYS(WAYS), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .resp_valid  (resp_valid),
   .resp_hit    (resp_hit),
   .resp_bypass (resp_bypass),
   .refill_req  (refill_req),
   .refill_ack  (refill_ack),
   .refill_addr (refill_addr),
   .alloc_fire  (alloc_fire),
   .alloc_way   (alloc_way),
   .lock_vec    (lock_vec),
   .dis_q       (dis_q)
);

// File: tb/cache_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module cache_lock_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_op = 3'd0;
   logic [31:0] req_addr = '0;
   logic [7:0]  way_disable = '0;
   logic        resp_valid, resp_hit, resp_bypass;
   logic [2:0]  resp_way;
   logic        refill_req;
   logic [31:0] refill_addr;
   logic        refill_ack = 1'b0;

   int vectors = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   cache_lock_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .way_disable(way_disable),
      .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_bypass(resp_bypass),
      .resp_way(resp_way), .refill_req(refill_req), .refill_addr(refill_addr),
      .refill_ack(refill_ack)
   );

   // Expected-state model built from the requirements
   logic [17:0] m_tag  [8][512];
   bit          m_val  [8][512];
   bit          m_lock [8][512];
   int          m_ctr = 0;

   function automatic logic [31:0] mk_addr(int tg, int st, int off);
      return {tg[17:0], st[8:0], off[4:0]};
   endfunction

   task automatic chk(string req, int act, int exp, string what);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model(input int op, input logic [31:0] a, input logic [7:0] dis,
                        output bit e_hit, output bit e_byp, output bit e_ref,
                        output int e_way, output string lbl);
      int st = int'(a[13:5]);
      logic [17:0] tg = a[31:14];
      int hw = -1, rw = -1, pw = -1;
      e_hit = 0; e_byp = 0; e_ref = 0; e_way = 0; lbl = "R3";
      for (int w = 0; w < 8; w++)
         if (hw < 0 && m_val[w][st] && m_tag[w][st] == tg) hw = w;
      e_hit = (hw >= 0);
      if (op <= 2) begin
         if (e_hit) begin
            e_way = hw;
            if (op == 2) begin m_lock[hw][st] = 1; lbl = "R8"; end
         end else begin
            e_ref = 1;
            for (int w = 0; w < 8; w++)
               if (rw < 0 && !m_val[w][st] && m_lock[w][st] && m_tag[w][st] == tg) rw = w;
            if (rw >= 0) begin
               e_way = rw; lbl = "R7";
            end else begin
               for (int i = 0; i < 8; i++) begin
                  int idx = (m_ctr + i) % 8;
                  if (pw < 0 && !m_lock[idx][st] && !dis[idx]) pw = idx;
               end
               if (pw >= 0) begin
                  e_way = pw; m_ctr = (pw + 1) % 8;
                  lbl = (op == 2) ? "R8" : "R4";
               end else begin
                  e_byp = 1; lbl = "R5";
               end
            end
            if (!e_byp) begin
               m_tag[e_way][st] = tg;
               m_val[e_way][st] = 1;
               if (op == 2) m_lock[e_way][st] = 1;
            end
         end
      end else if (op == 3) begin
         lbl = "R9";
         if (e_hit) e_way = hw;
         for (int w = 0; w < 8; w++)
            if (m_tag[w][st] == tg && (m_val[w][st] || m_lock[w][st])) m_lock[w][st] = 0;
      end else begin
         lbl = "R7";
         if (e_hit) begin e_way = hw; m_val[hw][st] = 0; end
      end
   endtask

   task automatic do_op(int op, logic [31:0] a, logic [7:0] dis, string force_lbl = "");
      bit e_hit, e_byp, e_ref;
      int e_way;
      string lbl;
      bit seen = 0;
      int wait_n = 0;
      logic [31:0] raddr = '0;
      bit got = 0;
      model(op, a, dis, e_hit, e_byp, e_ref, e_way, lbl);
      if (force_lbl != "") lbl = force_lbl;
      req_op = op[2:0]; req_addr = a; way_disable = dis; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int n = 0; n < 60; n++) begin
         @(negedge clk);
         if (refill_ack) refill_ack = 1'b0;
         if (resp_valid) begin got = 1; break; end
         if (refill_req) begin
            if (!seen) begin
               seen = 1; raddr = refill_addr; wait_n = int'($urandom % 3);
            end else if (refill_addr != raddr) begin
               chk("R10", int'(refill_addr), int'(raddr), "refill_addr stability");
            end
            if (wait_n == 0) refill_ack = 1'b1;
            else wait_n--;
         end
      end
      chk("R10", int'(got), 1, "response seen");
      if (!got) return;
      chk(lbl, int'(resp_hit), int'(e_hit), "resp_hit");
      chk(lbl, int'(resp_bypass), int'(e_byp), "resp_bypass");
      chk(lbl, int'(resp_way), e_way, "resp_way");
      chk(lbl, int'(seen), int'(e_ref), "refill issued");
      if (seen) chk("R1", int'(raddr), int'({a[31:5], 5'b0}), "refill_addr");
      @(negedge clk);
      chk("R10", int'(resp_valid), 0, "resp pulse width");
      chk("R10", int'(req_ready), 1, "ready when idle");
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int w = 0; w < 8; w++)
         for (int s = 0; s < 512; s++) begin
            m_tag[w][s] = '0; m_val[w][s] = 0; m_lock[w][s] = 0;
         end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: idle state after reset
      chk("R2", int'(req_ready), 1, "ready after reset");
      chk("R2", int'(resp_valid), 0, "no response after reset");
      chk("R2", int'(refill_req), 0, "no refill after reset");
      // R2: first read misses into way 0
      do_op(0, mk_addr(1, 5, 0), 8'h00, "R2");
      do_op(0, mk_addr(1, 5, 7), 8'h00, "R3");
      do_op(1, mk_addr(1, 5, 31), 8'h00, "R3");
      // R8: lock-on-miss fills ways 1..7, then lock-on-hit of way 0
      for (int t = 2; t <= 8; t++) do_op(2, mk_addr(t, 5, 0), 8'h00, "R8");
      do_op(2, mk_addr(1, 5, 0), 8'h00, "R8");
      // R5: fully locked set bypasses, twice
      do_op(0, mk_addr(9, 5, 4), 8'h00, "R5");
      do_op(1, mk_addr(9, 5, 0), 8'h00, "R5");
      // R6: locked lines survive
      do_op(0, mk_addr(1, 5, 0), 8'h00, "R6");
      do_op(0, mk_addr(8, 5, 0), 8'h00, "R6");
      // R7: invalidate a locked line, then refill into the same way
      do_op(4, mk_addr(3, 5, 0), 8'h00, "R7");
      do_op(0, mk_addr(3, 5, 0), 8'h00, "R7");
      do_op(0, mk_addr(3, 5, 0), 8'h00, "R7");
      // R9: unlock one way, then a miss replaces it
      do_op(3, mk_addr(5, 5, 0), 8'h00, "R9");
      do_op(0, mk_addr(10, 5, 0), 8'h00, "R9");
      // R4: pointer wraps past disabled ways in a fresh set
      do_op(0, mk_addr(1, 6, 0), 8'he0, "R4");
      // R11: hit leaves pointer; shared pointer used in another set
      do_op(0, mk_addr(1, 6, 0), 8'h00, "R11");
      do_op(0, mk_addr(2, 7, 0), 8'h00, "R11");
      // unlock set 5 fully so random traffic has room
      for (int t = 1; t <= 8; t++) do_op(3, mk_addr(t, 5, 0), 8'h00, "R9");
      // constrained random traffic on a few sets and tags
      for (int k = 0; k < 500; k++) begin
         int r = int'($urandom % 100);
         int op = (r < 40) ? 0 : (r < 58) ? 1 : (r < 72) ? 2 : (r < 86) ? 3 : 4;
         int sel = int'($urandom % 3);
         int st = (sel == 0) ? 2 : (sel == 1) ? 3 : 511;
         int tg = 1 + int'($urandom % 12);
         logic [7:0] dis = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
         do_op(op, mk_addr(tg, st, int'($urandom % 32)), dis);
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule